// File: doc/BRIEF.md
# Serial Transmitter with Interrupt Control

This block is the transmit side of an asynchronous serial port, together with the control register and the interrupt request logic for the whole port. Software writes a control byte and data bytes through a small write/read port. The block sends each data byte on a single output line as a framed word. It moves one bit for every pulse on a bit-rate tick input, which comes from a baud generator outside the block.

The block combines four event flags with enable bits from the control register to form one level-sensitive interrupt request. Two of the flags come from the transmitter itself: data register empty and transmission complete. The receive-full, overrun and idle-line flags come from a receiver outside the block. Two transmitter-enable rules govern start-up and line breaks. When the enable goes from 0 to 1 while the line is quiet, the first bit time is spent waiting before any frame starts. When the enable goes 0 and then 1 while a frame is being sent, one all-ones frame is queued as an idle preamble after that frame.

Top module: `uart_tx_irqctl`

## Requirements
- R1: After reset the control register reads 0x00, `txd_o` is 1, `txd_oe_o` is 0, `irq_o` is 0, and both `tx_empty_o` and `tx_done_o` are 1.
- R2: A write with `reg_sel`=0 loads the control register. Bit 7 is the transmit-empty interrupt enable, bit 6 the complete interrupt enable, bit 5 the receive interrupt enable, bit 4 the idle interrupt enable, bit 3 the transmitter enable (TE) and bit 2 the receiver enable. Bits 1:0 always read 0. A read with `reg_sel`=0 returns the control register. A read with `reg_sel`=1 returns the empty flag in bit 7, the complete flag in bit 6 and zeros below.
- R3: A frame is a 0 start bit, then 8 data bits least significant first, then a 1 stop bit. A new bit is presented after each `bit_tick`. The line rests at 1 between frames and changes only after a tick.
- R4: When bit 7 is set and the empty flag is 1, `irq_o` is 1.
- R5: When bit 6 is set and the complete flag is 1, `irq_o` is 1.
- R6: When bit 5 is set and either `rx_ovr_i` or `rx_full_i` is 1, `irq_o` is 1.
- R7: When bit 4 is set and `rx_idle_i` is 1, `irq_o` is 1. `irq_o` is the level OR of the four enabled conditions and is 0 when none holds.
- R8: A data write (`reg_sel`=1) clears the empty and complete flags in the next cycle. The empty flag sets when the byte enters the shifter. The complete flag sets when a stop bit ends with no byte and no preamble pending.
- R9: Writing TE to 0 and then to 1 while a frame is on the line queues one preamble of 10 ones. The preamble is sent right after that frame and before any pending byte.
- R10: When TE rises while the line is quiet, the first following tick starts nothing. The earliest start bit begins at the second tick.
- R11: `txd_o` is driven (`txd_oe_o`=1) whenever TE or the receiver enable is 1. It is released only when both are 0.
- R12: Frames start only on a tick with TE=1. Clearing TE mid-frame lets that frame finish, and the pending bytes are held. Back-to-back frames follow with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control register, 1 selects data/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| rx_full_i | input | 1 | Receive data register full flag from receiver |
| rx_ovr_i | input | 1 | Overrun flag from receiver |
| rx_idle_i | input | 1 | Idle-line flag from receiver |
| txd_o | output | 1 | Serial output line |
| txd_oe_o | output | 1 | Output enable for the serial pin |
| irq_o | output | 1 | Combined interrupt request level |
| tx_empty_o | output | 1 | Data register empty flag |
| tx_done_o | output | 1 | Transmission complete flag |

## Verification
The transmitter is first given a byte while TE is off, which shows that nothing leaves the line until enabled. It is then enabled with a byte pending, which separates the one-bit start-up wait from an immediate start. A second byte is written mid-frame to show back-to-back framing, and 0xA5, 0x3C, 0x81, 0x42 and 0x55 expose bit order and stop-bit placement. A TE pulse during a frame shows whether the preamble goes before the queued byte. Each interrupt enable is set alone while its flag is toggled, and the receiver enable is set alone, so that a wrongly wired enable or output-enable term is singled out.

// File: rtl/sertx_pkg.sv
// Shared constants and the control register layout for the serial transmitter.
// Assumes an 8-bit register port; bit positions are fixed by software.
package sertx_pkg;

    localparam int CTRL_W = 8;

    // Control register fields, most significant bit first.
    typedef struct packed {
        logic       en_empty;   // bit 7: interrupt on data register empty
        logic       en_done;    // bit 6: interrupt on transmission complete
        logic       en_rx;      // bit 5: interrupt on receive full or overrun
        logic       en_idle;    // bit 4: interrupt on idle line
        logic       tx_en;      // bit 3: transmitter enable
        logic       rx_en;      // bit 2: receiver enable
        logic [1:0] unused;     // bits 1:0: read as zero
    } ctrl_t;

    localparam int N_IRQ_SRC = 4;

endpackage

// File: rtl/sertx_ctrl_reg.sv
// Control register of the serial port.
// Holds the enables and reports a rising edge of the transmitter enable.
// Assumes writes are single-cycle strobes; bits 1:0 are never stored.
module sertx_ctrl_reg
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic              te_rise
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_new;

    // Mask the reserved bits of an incoming write.
    always_comb begin
        ctrl_new        = ctrl_t'(wdata);
        ctrl_new.unused = 2'b00;
    end

    // A write that turns the transmitter on from off.
    assign te_rise = wr_en && ctrl_new.tx_en && !ctrl_q.tx_en;

    // Register update on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_new;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/sertx_shifter.sv
// Transmit engine: data holding register, frame shifter and transmit flags.
// Frames are start(0), DATA_W bits LSB first, stop(1); one bit per tick.
// Assumes te_rise is a one-cycle pulse and bit_tick a one-cycle pulse.
module sertx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              te_rise,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              empty,
    output logic              done
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [DATA_W-1:0]  hold_q;
    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               busy_q;
    logic               empty_q;
    logic               done_q;
    logic               guard_q;
    logic               pre_q;

    logic last_bit;
    logic have_work;
    logic start;
    logic finish;

    // Decode the frame boundaries and the start condition.
    always_comb begin
        last_bit  = busy_q && (cnt_q == '0);
        have_work = pre_q || !empty_q;
        start     = bit_tick && tx_en && !guard_q && have_work
                    && (!busy_q || last_bit);
        finish    = bit_tick && last_bit;
    end

    // Holding register captures each data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (data_wr) begin
            hold_q <= wdata;
        end
    end

    // Frame shifter and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '1;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            sr_q   <= pre_q ? {FRAME_W{1'b1}} : {1'b1, hold_q, 1'b0};
            cnt_q  <= LAST_IDX;
            busy_q <= 1'b1;
        end else if (finish) begin
            sr_q   <= '1;
            busy_q <= 1'b0;
        end else if (bit_tick && busy_q) begin
            sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // One-bit-time wait after the transmitter is enabled on a quiet line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_q <= 1'b0;
        end else if (te_rise && !busy_q) begin
            guard_q <= 1'b1;
        end else if (bit_tick && !busy_q) begin
            guard_q <= 1'b0;
        end
    end

    // Idle preamble request from an enable pulse during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= 1'b0;
        end else if (te_rise && busy_q) begin
            pre_q <= 1'b1;
        end else if (start && pre_q) begin
            pre_q <= 1'b0;
        end
    end

    // Data register empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (data_wr) begin
            empty_q <= 1'b0;
        end else if (start && !pre_q) begin
            empty_q <= 1'b1;
        end
    end

    // Transmission complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b1;
        end else if (data_wr) begin
            done_q <= 1'b0;
        end else if (finish && !start && !have_work) begin
            done_q <= 1'b1;
        end
    end

    assign txd   = sr_q[0];
    assign empty = empty_q;
    assign done  = done_q;

endmodule

// File: rtl/sertx_irq_merge.sv
// Combines event flags with their enables into one level interrupt request.
// Assumes flags and enables are already registered or stable inputs.
module sertx_irq_merge #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] enable,
    output logic             irq
);

    logic [N_SRC-1:0] gated;

    // One gate per interrupt source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign gated[i] = flag[i] & enable[i];
    end

    // Any enabled source raises the request.
    assign irq = |gated;

endmodule

// File: rtl/uart_tx_irqctl.sv
// Top of the serial transmitter with control register and interrupt logic.
// Register port: reg_sel=0 control, reg_sel=1 data write / status read.
// Assumes bit_tick is a single-cycle pulse from an external rate generator.
module uart_tx_irqctl
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              rx_full_i,
    input  logic              rx_ovr_i,
    input  logic              rx_idle_i,
    output logic              txd_o,
    output logic              txd_oe_o,
    output logic              irq_o,
    output logic              tx_empty_o,
    output logic              tx_done_o
);

    ctrl_t                ctrl_q;
    logic                 te_rise;
    logic                 empty;
    logic                 done;
    logic [N_IRQ_SRC-1:0] irq_flag;
    logic [N_IRQ_SRC-1:0] irq_en;

    sertx_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr && !reg_sel),
        .wdata   (reg_wdata),
        .ctrl    (ctrl_q),
        .te_rise (te_rise)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_tick(bit_tick),
        .tx_en   (ctrl_q.tx_en),
        .te_rise (te_rise),
        .data_wr (reg_wr && reg_sel),
        .wdata   (reg_wdata[DATA_W-1:0]),
        .txd     (txd_o),
        .empty   (empty),
        .done    (done)
    );

    // Pair each event flag with its enable bit.
    always_comb begin
        irq_flag = {empty, done, rx_ovr_i | rx_full_i, rx_idle_i};
        irq_en   = {ctrl_q.en_empty, ctrl_q.en_done, ctrl_q.en_rx, ctrl_q.en_idle};
    end

    sertx_irq_merge #(.N_SRC(N_IRQ_SRC)) u_irq (
        .flag   (irq_flag),
        .enable (irq_en),
        .irq    (irq_o)
    );

    // Read mux: control byte or transmit status.
    always_comb begin
        if (reg_sel) begin
            reg_rdata = {empty, done, {(CTRL_W-2){1'b0}}};
        end else begin
            reg_rdata = ctrl_q;
        end
    end

    assign txd_oe_o   = ctrl_q.tx_en | ctrl_q.rx_en;
    assign tx_empty_o = empty;
    assign tx_done_o  = done;

endmodule

// File: rtl/sertx_chk.sv
// Protocol checker for uart_tx_irqctl, attached with bind.
// Assumes the synchronous active-low reset of the design.
module sertx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [1:0] wdata_en,
    input logic [3:0] irq_en,
    input logic       rx_full_i,
    input logic       rx_ovr_i,
    input logic       rx_idle_i,
    input logic       txd_o,
    input logic       txd_oe_o,
    input logic       irq_o,
    input logic       tx_empty_o,
    input logic       tx_done_o
);

    // R3
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd_o));

    // R8
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel |=> !tx_empty_o && !tx_done_o);

    // R4
    empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en[3] && tx_empty_o |-> irq_o);

    // R5
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en[2] && tx_done_o |-> irq_o);

    // R6
    rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en[1] && (rx_ovr_i || rx_full_i) |-> irq_o);

    // R7
    idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en[0] && rx_idle_i |-> irq_o);

    // R7
    no_src_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en == 4'b0000 |-> !irq_o);

    // R11
    pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_sel && wdata_en == 2'b00 |=> !txd_oe_o);

    // R12
    done_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> txd_o);

endmodule

bind uart_tx_irqctl sertx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .wdata_en  (reg_wdata[3:2]),
    .irq_en    (ctrl_q[7:4]),
    .rx_full_i (rx_full_i),
    .rx_ovr_i  (rx_ovr_i),
    .rx_idle_i (rx_idle_i),
    .txd_o     (txd_o),
    .txd_oe_o  (txd_oe_o),
    .irq_o     (irq_o),
    .tx_empty_o(tx_empty_o),
    .tx_done_o (tx_done_o)
);

// File: tb/uart_tx_irqctl_tb.sv
// Bench: behavioural queue-based reference model compared on every clock,
// plus directed checks for reset and the start-up wait.
module uart_tx_irqctl_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       rx_full_i, rx_ovr_i, rx_idle_i;
    logic       txd_o, txd_oe_o, irq_o, tx_empty_o, tx_done_o;
    logic       tick_on;
    logic       bit_tick;
    int unsigned cyc;

    int checks = 0;
    int errs   = 0;

    always #(CLK_P/2) clk = ~clk;

    // Tick every fourth cycle; counter moves only at the rising edge.
    always @(posedge clk) cyc <= cyc + 1;
    assign bit_tick = tick_on && (cyc[1:0] == 2'd3);

    uart_tx_irqctl u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rx_full_i(rx_full_i), .rx_ovr_i(rx_ovr_i), .rx_idle_i(rx_idle_i),
        .txd_o(txd_o), .txd_oe_o(txd_oe_o), .irq_o(irq_o),
        .tx_empty_o(tx_empty_o), .tx_done_o(tx_done_o)
    );

    // ---------------- reference model ----------------
    bit       line_q[$];
    bit [7:0] m_ctrl;
    bit [7:0] m_hold;
    bit       m_empty, m_done, m_guard, m_pre;

    always @(posedge clk) begin
        bit was_busy;
        bit ended;
        if (!rst_n) begin
            line_q.delete();
            m_ctrl = 8'h00; m_hold = 8'h00;
            m_empty = 1'b1; m_done = 1'b1; m_guard = 1'b0; m_pre = 1'b0;
        end else begin
            was_busy = (line_q.size() != 0);
            ended    = 1'b0;
            if (bit_tick) begin
                if (was_busy) begin
                    void'(line_q.pop_front());
                    ended = (line_q.size() == 0);
                end
                if (!was_busy && m_guard) begin
                    m_guard = 1'b0;
                end else if (line_q.size() == 0 && m_ctrl[3] && (m_pre || !m_empty)) begin
                    if (m_pre) begin
                        for (int i = 0; i < 10; i++) line_q.push_back(1'b1);
                        m_pre = 1'b0;
                    end else begin
                        line_q.push_back(1'b0);
                        for (int i = 0; i < 8; i++) line_q.push_back(m_hold[i]);
                        line_q.push_back(1'b1);
                        m_empty = 1'b1;
                    end
                end else if (ended && m_empty && !m_pre) begin
                    m_done = 1'b1;
                end
            end
            if (reg_wr && !reg_sel) begin
                if (reg_wdata[3] && !m_ctrl[3]) begin
                    if (was_busy) m_pre = 1'b1;
                    else          m_guard = 1'b1;
                end
                m_ctrl = reg_wdata & 8'hFC;
            end
            if (reg_wr && reg_sel) begin
                m_hold = reg_wdata; m_empty = 1'b0; m_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every clock, a quarter period after the edge.
    always @(posedge clk) begin
        bit m_line, m_irq;
        bit [7:0] m_rd;
        #(CLK_P/4);
        if (rst_n) begin
            m_line = (line_q.size() != 0) ? line_q[0] : 1'b1;
            m_irq  = (m_ctrl[7] && m_empty) || (m_ctrl[6] && m_done) ||
                     (m_ctrl[5] && (rx_ovr_i || rx_full_i)) || (m_ctrl[4] && rx_idle_i);
            m_rd   = reg_sel ? {m_empty, m_done, 6'b0} : m_ctrl;
            chk(txd_o === m_line, "R3/R9/R10/R12 line", txd_o, m_line);
            chk(txd_oe_o === (m_ctrl[3] | m_ctrl[2]), "R11 output enable", txd_oe_o, m_ctrl[3] | m_ctrl[2]);
            chk(irq_o === m_irq, "R4/R5/R6/R7 irq", irq_o, m_irq);
            chk(tx_empty_o === m_empty, "R8 empty", tx_empty_o, m_empty);
            chk(tx_done_o === m_done, "R8 done", tx_done_o, m_done);
            chk(reg_rdata === m_rd, "R2 read data", reg_rdata, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input bit sel, input bit [7:0] d);
        do @(negedge clk); while (bit_tick);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!bit_tick);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    initial begin
        #(CLK_P * 150000);
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
        rx_full_i = 1'b0; rx_ovr_i = 1'b0; rx_idle_i = 1'b0;
        tick_on = 1'b1; cyc = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(txd_o === 1'b1, "R1 txd", txd_o, 1);
        chk(txd_oe_o === 1'b0, "R1 oe", txd_oe_o, 0);
        chk(irq_o === 1'b0, "R1 irq", irq_o, 0);
        chk(tx_empty_o === 1'b1 && tx_done_o === 1'b1, "R1 flags",
            {tx_empty_o, tx_done_o}, 3);
        chk(reg_rdata === 8'h00, "R1 ctrl", reg_rdata, 0);

        // R12: byte written while disabled must stay put
        wr(1'b1, 8'hA5);
        wait_ticks(12);
        chk(txd_o === 1'b1, "R12 no send while disabled", txd_o, 1);

        // R10: one tick of wait, then start bit
        wr(1'b0, 8'h0B);
        wait_tick();
        chk(txd_o === 1'b1, "R10 first tick idle", txd_o, 1);
        wait_tick();
        chk(txd_o === 1'b0, "R10 start on second tick", txd_o, 0);
        // R2: reserved bits read zero
        chk(reg_rdata === 8'h08, "R2 reserved bits", reg_rdata, 8'h08);
        // R12: back-to-back second byte
        wait_ticks(3);
        wr(1'b1, 8'h3C);
        wait_ticks(25);

        // R4..R7: each enable alone with its flag toggled
        wr(1'b0, 8'h88);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h48);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h28);
        rx_full_i = 1'b1; repeat (3) @(negedge clk);
        rx_full_i = 1'b0; rx_ovr_i = 1'b1; repeat (3) @(negedge clk);
        rx_ovr_i = 1'b0; rx_idle_i = 1'b1; repeat (3) @(negedge clk);
        wr(1'b0, 8'h18);
        repeat (3) @(negedge clk);
        rx_idle_i = 1'b0; repeat (3) @(negedge clk);
        reg_sel = 1'b1; repeat (2) @(negedge clk); reg_sel = 1'b0;

        // R9: enable pulse mid-frame queues a preamble before next byte
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h81);
        wait_ticks(3);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h42);
        wait_ticks(36);

        // R12: clearing enable mid-frame lets the frame finish
        wr(1'b1, 8'h55);
        wait_ticks(3);
        wr(1'b0, 8'h00);
        wait_ticks(12);
        wr(1'b1, 8'h99);
        wait_ticks(12);
        chk(tx_done_o === 1'b0, "R8 done held with byte pending", tx_done_o, 0);

        // R11: receiver enable alone drives the pin, clearing both releases it
        wr(1'b0, 8'h04);
        @(negedge clk);
        chk(txd_oe_o === 1'b1, "R11 rx enable drives pin", txd_oe_o, 1);
        wr(1'b0, 8'h00);
        @(negedge clk);
        chk(txd_oe_o === 1'b0, "R11 pin released", txd_oe_o, 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule